// File: doc/BRIEF.md
# Watchdog Timer with Programmable Reset Pulse

The block is a register-mapped watchdog. A 32-bit down-counter steps once per 1 MHz tick enable, so one count is one microsecond. Software keeps it from expiring by writing a fixed key to the restart register, which reloads the counter from the reload register. When the counter steps down to zero while the watchdog is enabled, a timeout flag sets. If external signalling is also enabled, the block emits one reset pulse, and the reset request follows that pulse.

The pulse has three settings: its length in ticks, its polarity, and its pad drive style. The drive style is either push-pull or open-drain, where the pad output-enable is high only while the pulse is asserted. Polarity and drive style change only when a specific key byte is written to the top byte of the pulse configuration register. Any other top byte leaves both settings as they are. When alternate boot is enabled, an expiry also sets a boot-secondary flag, and that flag swaps the two flash chip selects until software clears the status.

The register map uses byte addresses: 0x00 current count (read-only), 0x04 reload, 0x08 restart (write-only), 0x0C control, 0x10 status (read-only), 0x14 status clear (write-only) and 0x18 pulse configuration.

Top module: `wdog_pulse`

## Requirements
- R1: After reset the state is as follows. Count (0x00) reads 30000000 and pulse configuration (0x18) reads 0x000000FF: active-low, open-drain, width 255. Status (0x10) reads 0. `reset_req`, `pad_oe` and `flash_cs_swap` are 0 and `pad_out` is 1.
- R2: The counter decreases by one on each cycle with `tick_1us` high, and only while control bit 0 (enable) is set. Without a tick, or while disabled, the counter holds its value.
- R3: A write of exactly 0x00004755 to 0x08 loads the counter from the reload register (0x04). A write of any other value to 0x08 leaves the counter unchanged.
- R4: When an enabled tick takes the counter from 1 to 0, status bit 0 (timeout) sets. The counter then stays at 0 until the next restart.
- R5: An expiry produces a pulse only when control bits 0 and 1 (external signal) are both set. A width field N keeps `reset_req` high for exactly N+1 ticks, and each expiry gives exactly one pulse.
- R6: Writing top byte 0xA5 to 0x18 selects active-high polarity, and writing 0x5A selects active-low. Bit 31 of 0x18 reads 1 when the polarity is active-high.
- R7: Writing top byte 0xA8 to 0x18 selects push-pull, and writing 0x8A selects open-drain. Bit 30 reads 1 for push-pull. Any other top byte leaves bits 31 and 30 unchanged, and bits 19:0 of every write to 0x18 set the width.
- R8: In push-pull mode `pad_oe` is always 1. In open-drain mode `pad_oe` is 1 only while the pulse is asserted. `pad_out` carries the asserted level during the pulse and the opposite level otherwise.
- R9: An expiry with control bit 2 (alternate boot) set sets status bit 1 and `flash_cs_swap`. Any write to 0x14 clears status bits 0 and 1 and restores the normal mapping. When the mapping is already normal, that write leaves `flash_cs_swap` at 0.
- R10: A valid restart write in the same cycle as the tick that would expire the counter takes priority. The counter reloads and no expiry occurs.
- R11: If a write to 0x14 lands in the same cycle as an expiry, it is ignored. The status bits come out set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle 1 MHz time-base enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_out | output | 1 | Reset pulse pad level |
| pad_oe | output | 1 | Pad output enable |
| reset_req | output | 1 | Reset request, high for the pulse duration |
| timeout_flag | output | 1 | Timeout status bit |
| flash_cs_swap | output | 1 | High when the flash chip selects are swapped |

## Verification
Two pairs of functions can collide in one cycle. A restart write can arrive on the very tick that would expire the counter, and a status-clear write can arrive on that same expiring tick. The bench sets the counter to 1 and then drives the tick together with the write in a single cycle. In the restart case it passes if the counter reads the reload value and the timeout flag stays clear. In the clear case it passes if the timeout flag reads set on the next read.

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int          AW         = 5,
  parameter int          WB         = 20,
  parameter logic [31:0] RELOAD_RST = 32'd30_000_000,
  parameter logic [31:0] WIDTH_RST  = 32'h0000_00FF,
  parameter logic [31:0] RESTART_KEY = 32'h0000_4755
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1us,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          pad_out,
  output logic          pad_oe,
  output logic          reset_req,
  output logic          timeout_flag,
  output logic          flash_cs_swap
);
  localparam logic [AW-1:0] A_COUNT   = AW'('h00);
  localparam logic [AW-1:0] A_RELOAD  = AW'('h04);
  localparam logic [AW-1:0] A_RESTART = AW'('h08);
  localparam logic [AW-1:0] A_CTRL    = AW'('h0C);
  localparam logic [AW-1:0] A_STATUS  = AW'('h10);
  localparam logic [AW-1:0] A_CLEAR   = AW'('h14);
  localparam logic [AW-1:0] A_PULSE   = AW'('h18);
  localparam logic [7:0] K_HIGH = 8'hA5, K_LOW = 8'h5A;
  localparam logic [7:0] K_PP   = 8'hA8, K_OD  = 8'h8A;

  logic [31:0]   cnt, reload;
  logic [2:0]    ctrl;
  logic          boot_sec;
  logic [WB-1:0] width, pcnt;
  logic          pol_high, push_pull, pulse_act;

  wire en      = ctrl[0];
  wire ext_en  = ctrl[1];
  wire alt     = ctrl[2];
  wire wr_rst  = bus_wr && bus_addr == A_RESTART && bus_wdata == RESTART_KEY;
  wire wr_clr  = bus_wr && bus_addr == A_CLEAR;
  wire wr_cfg  = bus_wr && bus_addr == A_PULSE;
  wire expire  = en && tick_1us && cnt == 32'd1 && !wr_rst;
  wire [7:0] top = bus_wdata[31:24];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       cnt <= RELOAD_RST;
    else if (wr_rst)                  cnt <= reload;
    else if (en && tick_1us && cnt != 0) cnt <= cnt - 32'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reload <= RELOAD_RST;
      ctrl   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_RELOAD) reload <= bus_wdata;
      if (bus_addr == A_CTRL)   ctrl   <= bus_wdata[2:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      timeout_flag <= 1'b0;
      boot_sec     <= 1'b0;
    end else if (expire) begin
      timeout_flag <= 1'b1;
      boot_sec     <= boot_sec | alt;
    end else if (wr_clr) begin
      timeout_flag <= 1'b0;
      boot_sec     <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      width     <= WIDTH_RST[WB-1:0];
      pol_high  <= 1'b0;
      push_pull <= 1'b0;
    end else if (wr_cfg) begin
      width <= bus_wdata[WB-1:0];
      case (top)
        K_HIGH:  pol_high  <= 1'b1;
        K_LOW:   pol_high  <= 1'b0;
        K_PP:    push_pull <= 1'b1;
        K_OD:    push_pull <= 1'b0;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pulse_act <= 1'b0;
      pcnt      <= '0;
    end else if (expire && ext_en) begin
      pulse_act <= 1'b1;
      pcnt      <= width;
    end else if (pulse_act && tick_1us) begin
      if (pcnt == 0) pulse_act <= 1'b0;
      else           pcnt <= pcnt - 1'b1;
    end

  assign reset_req     = pulse_act;
  assign pad_out       = pulse_act ? pol_high : ~pol_high;
  assign pad_oe        = push_pull | pulse_act;
  assign flash_cs_swap = boot_sec;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_COUNT:  bus_rdata = cnt;
      A_RELOAD: bus_rdata = reload;
      A_CTRL:   bus_rdata = {29'd0, ctrl};
      A_STATUS: bus_rdata = {30'd0, boot_sec, timeout_flag};
      A_PULSE:  bus_rdata = {pol_high, push_pull, 30'(width)};
      default:  bus_rdata = '0;
    endcase
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_rst) |=> $stable(cnt));
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> cnt == $past(reload));
  p_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_1us && cnt == 32'd1 && !wr_rst) |=> timeout_flag && cnt == 32'd0);
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(ctrl[0] && ctrl[1]));
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && top != K_HIGH && top != K_LOW && top != K_PP && top != K_OD)
      |=> $stable(pol_high) && $stable(push_pull));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !(en && tick_1us && cnt == 32'd1 && !wr_rst)) |=> !timeout_flag && !flash_cs_swap);
  p_race_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rst && !timeout_flag) |=> !timeout_flag);
endmodule

// File: tb/wdog_pulse_test.sv
module wdog_pulse_test;
  logic clk = 0, rst_n = 0, tick = 0, wr = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic pad_out, pad_oe, reset_req, timeout_flag, flash_cs_swap;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_pulse uut (.clk(clk), .rst_n(rst_n), .tick_1us(tick), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .reset_req(reset_req), .timeout_flag(timeout_flag),
    .flash_cs_swap(flash_cs_swap));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d, bit with_tick = 0);
    @(negedge clk); wr = 1; addr = a; wdata = d; tick = with_tick;
    @(negedge clk); wr = 0; tick = 0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic arm(logic [31:0] ctl, logic [31:0] rl);
    wr_reg(5'h0C, ctl); wr_reg(5'h04, rl); wr_reg(5'h08, 32'h4755); wr_reg(5'h14, 0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd_reg(5'h00, v); check("R1 count", v, 32'd30000000);
    rd_reg(5'h18, v); check("R1 cfg", v, 32'h000000FF);
    rd_reg(5'h10, v); check("R1 status", v, 0);
    check("R1 pins", {reset_req, pad_oe, flash_cs_swap, pad_out}, 4'b0001);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr_reg(5'h04, 10);
    wr_reg(5'h08, 32'h1234); rd_reg(5'h00, v); check("R3 bad key", v, 32'd30000000);
    wr_reg(5'h08, 32'h4755); rd_reg(5'h00, v); check("R3 key", v, 10);
  endtask

  task automatic t_count;
    logic [31:0] v;
    ticks(3); rd_reg(5'h00, v); check("R2 disabled", v, 10);
    wr_reg(5'h0C, 1); ticks(3); rd_reg(5'h00, v); check("R2 enabled", v, 7);
    repeat (5) @(negedge clk); rd_reg(5'h00, v); check("R2 no tick", v, 7);
  endtask

  task automatic t_pulse;
    logic [31:0] v;
    int n = 0;
    wr_reg(5'h18, 32'h0000_0002);
    arm(3, 4);
    ticks(3); check("R4 not yet", timeout_flag, 0);
    ticks(1);
    rd_reg(5'h10, v); check("R4 status", v, 1);
    rd_reg(5'h00, v); check("R4 count zero", v, 0);
    check("R5 req start", reset_req, 1);
    check("R8 od assert", {pad_out, pad_oe}, 2'b01);
    while (reset_req && n < 20) begin ticks(1); n++; end
    check("R5 width N+1", n, 3);
    check("R8 od release", {pad_out, pad_oe}, 2'b10);
    n = 0;
    for (int i = 0; i < 10; i++) begin ticks(1); n += reset_req; end
    check("R5 single pulse", n, 0);
  endtask

  task automatic t_noext;
    int n = 0;
    arm(1, 2);
    for (int i = 0; i < 6; i++) begin ticks(1); n += reset_req; end
    check("R5 no ext pulse", n, 0);
    check("R5 timeout still", timeout_flag, 1);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr_reg(5'h18, 32'hA500_0010); rd_reg(5'h18, v); check("R6 high", v, 32'h8000_0010);
    check("R8 idle level", pad_out, 0);
    wr_reg(5'h18, 32'hA800_0010); rd_reg(5'h18, v); check("R7 pp", v, 32'hC000_0010);
    check("R8 pp idle oe", pad_oe, 1);
    wr_reg(5'h18, 32'h3300_0005); rd_reg(5'h18, v); check("R7 other byte", v, 32'hC000_0005);
    wr_reg(5'h18, 32'h5A00_0005); rd_reg(5'h18, v); check("R6 low", v, 32'h4000_0005);
    wr_reg(5'h18, 32'h8A00_0005); rd_reg(5'h18, v); check("R7 od", v, 32'h0000_0005);
  endtask

  task automatic t_pp_pulse;
    wr_reg(5'h18, 32'hA500_0000); wr_reg(5'h18, 32'hA800_0000);
    arm(3, 1);
    ticks(1);
    check("R8 pp assert", {reset_req, pad_out, pad_oe}, 3'b111);
    ticks(1);
    check("R8 pp deassert", {reset_req, pad_out, pad_oe}, 3'b001);
  endtask

  task automatic t_altboot;
    logic [31:0] v;
    wr_reg(5'h14, 0); check("R9 normal clear", flash_cs_swap, 0);
    arm(5, 1);
    ticks(1);
    rd_reg(5'h10, v); check("R9 status", v, 3);
    check("R9 swap", flash_cs_swap, 1);
    wr_reg(5'h14, 32'hFFFF_FFFF);
    rd_reg(5'h10, v); check("R9 cleared", v, 0);
    check("R9 unswap", flash_cs_swap, 0);
  endtask

  task automatic t_races;
    logic [31:0] v;
    arm(1, 2); ticks(1);
    wr_reg(5'h08, 32'h4755, 1);
    rd_reg(5'h00, v); check("R10 reloaded", v, 2);
    check("R10 no expiry", timeout_flag, 0);
    ticks(1);
    wr_reg(5'h14, 0, 1);
    rd_reg(5'h10, v); check("R11 flag kept", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_restart; t_count; t_pulse; t_noext; t_cfg; t_pp_pulse; t_altboot; t_races;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule